// File: doc/BRIEF.md
# Even-Ratio Converter Core Clock Divider

This block derives the clock that paces a data converter core from a faster source clock. A 7-bit divide setting selects the length of the core clock period. The period is always an even number of source cycles, so the derived clock can be exactly 50% duty. Settings 0 and 1 both divide by two. Any setting N of 2 or more divides by 2N, which gives a longest period of 254 source cycles at N = 127.

Along with the divided clock, the block gives two one-cycle strobes in the source domain. The first is a tick at every rising edge of the core clock, which downstream counters use as an enable. The second is an "applied" pulse that marks the first period run at a new ratio. The divide setting is sampled only when a period ends, so a change in mid-period never shortens or stretches the period in progress.

Reset is asynchronous and active low, and its release is synchronised inside the block. Reset selects divide-by-two.

Top module: `core_clk_div`

## Requirements
- R1: Divide settings 0 and 1 each give a core clock period of 2 source cycles, with the output high for 1 cycle and low for 1 cycle.
- R2: A divide setting N in the range 2 to 127 gives a core clock period of exactly 2N source cycles (4 for N=2, 6 for N=3, 254 for N=127).
- R3: In every period the core clock is high for the first half of the period and low for the second half.
- R4: `core_tick` is high for exactly one source cycle, in the same cycle that `core_clk` goes from low to high, and at no other time.
- R5: The divide setting is sampled only on the source edge that begins a new period. A change made at any other time leaves the period in progress at its old length, and the following period uses the new setting.
- R6: `cfg_applied` is high for one cycle, together with `core_tick`, when the period just begun has a different ratio from the previous one. Settings 0 and 1 have the same ratio, so a change between them gives no pulse.
- R7: While `rst_n` is low, all three outputs are low. The ratio after reset is divide-by-two. The first tick comes on the third rising source edge after `rst_n` goes high, because two cycles are spent synchronising the reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 7 | Divide setting N (period = 2*max(N,1) source cycles) |
| core_clk | output | 1 | Divided core clock, 50% duty |
| core_tick | output | 1 | One-cycle strobe at each core clock rising edge |
| cfg_applied | output | 1 | One-cycle strobe when a new ratio takes effect |

## Verification
The bench sweeps settings 0, 1, 2, 3 and 127, then several mid-range values. For each one it measures the period length and the count of high cycles from tick to tick. A design that treated 1 as divide-by-one, or that added one to the setting, would give the wrong period. A design that changed phase at the wrong count would give uneven duty. The bench changes the setting just after a tick and checks that the current period keeps its old length. A design that loaded the setting at once would produce a short period or a glitch. The bench also steps the setting between 0 and 1 to check that no `cfg_applied` pulse appears. It measures the exact edge of the first tick after reset, which catches a wrong reset phase or synchroniser depth.

// File: rtl/core_clk_div_pkg.sv
package core_clk_div_pkg;

  // Smallest half-period in source cycles (divide-by-two).
  localparam int unsigned HALF_MIN = 1;

  // Number of flops in the reset-release synchroniser.
  localparam int unsigned RST_STAGES = 2;

  // Current phase of the core clock within one period.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

endpackage

// File: rtl/ccd_rst_sync.sv
module ccd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ccd_ratio_dec.sv
module ccd_ratio_dec #(
  parameter int unsigned DIV_W = 7
) (
  input  logic [DIV_W-1:0] sel,
  output logic [DIV_W-1:0] half
);

  // Settings below two both map to the minimum half-period.
  always_comb begin
    if (sel < DIV_W'(2)) begin
      half = DIV_W'(core_clk_div_pkg::HALF_MIN);
    end else begin
      half = sel;
    end
  end

endmodule

// File: rtl/ccd_phase_ctr.sv
module ccd_phase_ctr #(
  parameter int unsigned DIV_W = 7,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_new,
  output logic             start_d,
  output logic             changed_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [DIV_W-1:0] half_d
);

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_q;
  logic             last_q;
  logic             last_d;

  // Next-state: wrap and load a new ratio only when the period ends.
  always_comb begin
    start_d = last_q;
    if (last_q) begin
      half_d    = half_new;
      cnt_d     = '0;
      changed_d = (half_new != half_q);
    end else begin
      half_d    = half_q;
      cnt_d     = cnt_q + CNT_W'(1);
      changed_d = 1'b0;
    end
    last_d = (cnt_d == ({half_d, 1'b0} - CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= DIV_W'(core_clk_div_pkg::HALF_MIN);
      last_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ccd_out_reg.sv
module ccd_out_reg #(
  parameter int unsigned DIV_W = 7,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_d,
  input  logic             changed_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [DIV_W-1:0] half_d,
  output logic             core_clk,
  output logic             core_tick,
  output logic             cfg_applied
);

  import core_clk_div_pkg::*;

  phase_e phase_d;
  phase_e phase_q;
  logic   tick_q;
  logic   applied_q;

  always_comb begin
    phase_d = (cnt_d < {1'b0, half_d}) ? PH_HIGH : PH_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_LOW;
      tick_q    <= 1'b0;
      applied_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      tick_q    <= start_d;
      applied_q <= start_d & changed_d;
    end
  end

  assign core_clk    = (phase_q == PH_HIGH);
  assign core_tick   = tick_q;
  assign cfg_applied = applied_q;

endmodule

// File: rtl/core_clk_div.sv
module core_clk_div #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic             core_clk,
  output logic             core_tick,
  output logic             cfg_applied
);

  localparam int unsigned CNT_W = DIV_W + 1;

  logic             rst_n_i;
  logic [DIV_W-1:0] half_new;
  logic             start_d;
  logic             changed_d;
  logic [CNT_W-1:0] cnt_d;
  logic [DIV_W-1:0] half_d;

  ccd_rst_sync #(
    .STAGES(core_clk_div_pkg::RST_STAGES)
  ) u_rst_sync (
    .clk        (clk_src),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_i)
  );

  ccd_ratio_dec #(
    .DIV_W(DIV_W)
  ) u_ratio_dec (
    .sel (div_sel),
    .half(half_new)
  );

  ccd_phase_ctr #(
    .DIV_W(DIV_W)
  ) u_phase_ctr (
    .clk      (clk_src),
    .rst_n    (rst_n_i),
    .half_new (half_new),
    .start_d  (start_d),
    .changed_d(changed_d),
    .cnt_d    (cnt_d),
    .half_d   (half_d)
  );

  ccd_out_reg #(
    .DIV_W(DIV_W)
  ) u_out_reg (
    .clk        (clk_src),
    .rst_n      (rst_n_i),
    .start_d    (start_d),
    .changed_d  (changed_d),
    .cnt_d      (cnt_d),
    .half_d     (half_d),
    .core_clk   (core_clk),
    .core_tick  (core_tick),
    .cfg_applied(cfg_applied)
  );

endmodule

// File: rtl/core_clk_div_chk.sv
module core_clk_div_chk #(
  parameter int unsigned DIV_W = 7,
  localparam int unsigned CW = DIV_W + 2
) (
  input logic             clk_src,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_sel,
  input logic             core_clk,
  input logic             core_tick,
  input logic             cfg_applied
);

  logic [CW-1:0] gap_q;
  logic [CW-1:0] hi_q;
  logic          seen_q;

  // Track period length and high time between ticks.
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      hi_q   <= '0;
      seen_q <= 1'b0;
    end else if (core_tick) begin
      gap_q  <= CW'(1);
      hi_q   <= CW'(1);
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + CW'(1);
      hi_q   <= hi_q + CW'(core_clk);
    end
  end

  // R4
  tick_on_rise_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(core_clk) |-> core_tick);

  // R4
  tick_only_rise_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    core_tick |-> (core_clk && !$past(core_clk)));

  // R6
  applied_with_tick_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    cfg_applied |-> core_tick);

  // R3
  half_duty_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (core_tick && seen_q) |-> ({hi_q, 1'b0} == {1'b0, gap_q}));

  // R2
  period_range_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (core_tick && seen_q) |-> (gap_q >= CW'(2) && gap_q <= CW'(2 * ((1 << DIV_W) - 1))));

  logic unused_sel;
  assign unused_sel = ^div_sel;

endmodule

bind core_clk_div core_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_src    (clk_src),
  .rst_n      (rst_n),
  .div_sel    (div_sel),
  .core_clk   (core_clk),
  .core_tick  (core_tick),
  .cfg_applied(cfg_applied)
);

// File: tb/core_clk_div_tb.sv
module core_clk_div_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] div_sel;
  logic       core_clk;
  logic       core_tick;
  logic       cfg_applied;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  core_clk_div u_dut (
    .clk_src    (clk),
    .rst_n      (rst_n),
    .div_sel    (div_sel),
    .core_clk   (core_clk),
    .core_tick  (core_tick),
    .cfg_applied(cfg_applied)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference: position within period and half length.
  int m_edges, m_pos, m_half, h_new;
  bit m_run;
  bit e_clk, e_tick, e_app;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_run = 0; m_pos = 0; m_half = 1;
      e_clk = 0; e_tick = 0; e_app = 0;
    end else if (m_edges < 2) begin
      m_edges++;
    end else begin
      if (!m_run || m_pos == 2 * m_half - 1) begin
        h_new  = (div_sel < 2) ? 1 : int'(div_sel);
        e_app  = (h_new != m_half);
        m_half = h_new;
        m_pos  = 0;
        m_run  = 1;
      end else begin
        m_pos++;
        e_app = 0;
      end
      e_tick = (m_pos == 0);
      e_clk  = (m_pos < m_half);
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 core_clk vs model", int'(core_clk), int'(e_clk));
      chk("R4 core_tick vs model", int'(core_tick), int'(e_tick));
      chk("R6 cfg_applied vs model", int'(cfg_applied), int'(e_app));
    end
  end

  task automatic wait_tick(input string tag);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (core_tick) return;
    end
    chk({tag, " tick timeout"}, 0, 1);
  endtask

  // Called at a tick; returns length and high count of that period.
  task automatic measure(output int per, output int hi);
    per = 1;
    hi  = int'(core_clk);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (core_tick) return;
      per++;
      hi += int'(core_clk);
    end
  endtask

  initial begin
    int per, hi, prev_half, h;
    int vals[8] = '{1, 0, 2, 3, 127, 4, 64, 9};
    rst_n   = 1'b0;
    div_sel = 7'd0;
    cmp_en  = 1'b1;
    repeat (3) @(negedge clk);
    // R7: outputs low in reset
    chk("R7 core_clk in reset", int'(core_clk), 0);
    chk("R7 core_tick in reset", int'(core_tick), 0);
    chk("R7 cfg_applied in reset", int'(cfg_applied), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 no tick before third edge", int'(core_tick), 0);
    @(negedge clk);
    chk("R7 first tick on third edge", int'(core_tick), 1);
    chk("R7 no applied at default ratio", int'(cfg_applied), 0);
    measure(per, hi);
    chk("R1 default period", per, 2);
    chk("R3 default high time", hi, 1);
    prev_half = 1;

    for (int k = 0; k < 8; k++) begin
      div_sel = 7'(vals[k]);
      wait_tick("R2 sweep");
      h = (vals[k] < 2) ? 1 : vals[k];
      chk("R6 applied on ratio change", int'(cfg_applied), int'(h != prev_half));
      measure(per, hi);
      chk((vals[k] < 2) ? "R1 period" : "R2 period", per, 2 * h);
      chk("R3 high time", hi, h);
      prev_half = h;
    end

    // R5: change right after a tick; current period keeps old length.
    div_sel = 7'd3;
    wait_tick("R5 setup");
    measure(per, hi);
    div_sel = 7'd10;
    measure(per, hi);
    chk("R5 period in progress kept", per, 6);
    chk("R6 applied at new ratio", int'(cfg_applied), 1);
    measure(per, hi);
    chk("R5 next period uses new ratio", per, 20);
    chk("R3 high time after change", hi, 10);

    done = 1'b1;
    report();
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      report();
    end
  end

endmodule